// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block takes one asynchronous serial input line and turns each incoming character into a byte held in a single-entry receive buffer. The line is oversampled sixteen times per bit, and a programmable divider sets the length of one oversampling tick in clock cycles. A frame has a low start bit, eight data bits sent least significant first, an optional parity bit and one high stop bit.

Software reaches the block through a small word-wide register port. There is a data register, a status register and a control register. The status register holds three sticky error flags and a buffer-full bit. The control register selects the parity mode. One interrupt output pulses when a frame finishes. That pulse covers both clean frames and frames with an error. Software reads status first, then data, and clears error flags by writing zeros to them.

Register map (`regAddr`): 0 = received data (a read strobe empties the buffer), 1 = status, 2 = control. Status bits: bit 0 parity error, bit 1 framing error, bit 2 overrun, bit 3 buffer full (read-only). Control bits [1:0] set the parity mode: 00 none, 01 none (reserved), 10 even, 11 odd.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status register reads 0x00, the data register reads 0x00 and `rxIrq` is low.
- R2: A valid frame stores its eight data bits, first received bit in bit 0, in the data register and sets status bit 3. `rxIrq` pulses high for exactly one clock cycle per frame.
- R3: With control mode 10 (even) or 11 (odd), the bit after the eighth data bit is checked as parity. A bit that does not match the mode sets status bit 0 in the cycle `rxIrq` pulses. A bit that matches leaves bit 0 clear.
- R4: With control mode 00 or 01, no parity bit is expected: the stop bit follows the eighth data bit, and status bit 0 never sets.
- R5: A stop bit sampled low sets status bit 1. The data byte is still stored and `rxIrq` still pulses. The receiver then ignores the line until it returns high, so a line held low afterwards produces no further frame.
- R6: A frame that completes while status bit 3 is set sets status bit 2, and the new byte replaces the buffered one.
- R7: A read strobe on address 0 clears status bit 3, unless a frame completes in that same cycle.
- R8: A status write clears each error flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R9: When a status write of 0 meets a hardware set of the same flag in one cycle, the flag ends set.
- R10: A low pulse on the line shorter than half a bit period is not taken as a start bit: no interrupt and no stored byte follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idle high |
| divisor | input | 8 | Clock cycles per oversampling tick (0 and 1 both mean every cycle) |
| regAddr | input | 2 | Register select: 0 data, 1 status, 2 control |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (empties the buffer on address 0) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for the selected address, combinational |
| rxIrq | output | 1 | One-cycle reception interrupt pulse |

## Verification
A fault in the sampling state machine shows up first as a wrong byte, or as a missing or extra interrupt, at the middle of the stop bit of the frame where it strikes. A fault in the tick or sub-bit counter shifts every later sample, so the byte read after that interrupt already disagrees. Flag or buffer-full faults show in the first status read after the interrupt, or in the read right after a clearing write or data read. Leaving the line low after a bad stop bit, and sending glitches shorter than half a bit, test that the receiver stays quiet when it should: any spurious frame appears as an extra interrupt within one frame time.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Register addresses (the address decode depends on these values)
  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  // Status bit positions
  localparam int BIT_PAR  = 0;
  localparam int BIT_FRM  = 1;
  localparam int BIT_OVR  = 2;
  localparam int BIT_FULL = 3;

  // Sample strobes from the control FSM to the datapath
  typedef struct packed {
    logic dataBit;    // mid-point of a data bit
    logic parityBit;  // mid-point of the parity bit
    logic stopBit;    // mid-point of the stop bit
    logic level;      // synchronized line level at the strobe
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rxState_e;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic [DIV_W-1:0] divisor,
  input  logic             parityOn,
  output rxStrobe_t        strb
);

  localparam int SUB_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OSR / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  logic             rxMeta, rxSync;
  logic [DIV_W-1:0] divCnt;
  logic [SUB_W-1:0] subCnt;
  logic [BIT_W-1:0] bitCnt;
  rxState_e         state;
  logic             tick, sampleMid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
    end
  end

  assign tick      = (divisor <= DIV_W'(1)) || (divCnt >= divisor - DIV_W'(1));
  assign sampleMid = tick && (subCnt == SUB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      subCnt <= '0;
      bitCnt <= '0;
    end else if (state == ST_IDLE) begin
      divCnt <= '0;
      subCnt <= '0;
      bitCnt <= '0;
      if (!rxSync) state <= ST_START;
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick) subCnt <= subCnt + SUB_W'(1);
      case (state)
        ST_START: if (tick && subCnt == SUB_HALF) begin
          subCnt <= '0;
          state  <= rxSync ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (sampleMid) begin
          bitCnt <= bitCnt + BIT_W'(1);
          if (bitCnt == BIT_LAST) state <= parityOn ? ST_PAR : ST_STOP;
        end
        ST_PAR:    if (sampleMid) state <= ST_STOP;
        ST_STOP:   if (sampleMid) state <= rxSync ? ST_IDLE : ST_WAITHI;
        ST_WAITHI: if (rxSync) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.dataBit   = (state == ST_DATA) && sampleMid;
    strb.parityBit = (state == ST_PAR)  && sampleMid;
    strb.stopBit   = (state == ST_STOP) && sampleMid;
    strb.level     = rxSync;
  end

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strb,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [DATA_BITS-1:0] regWrData,
  output logic [DATA_BITS-1:0] regRdData,
  output logic                 rxIrq,
  output logic                 parityOn,
  output logic [1:0]           parMode,
  output logic [2:0]           errFlags,
  output logic                 bufFull
);

  logic [DATA_BITS-1:0] shiftReg, rxBuf;
  logic                 parBad;
  logic                 rdData, wrStatus;
  logic [2:0]           setFlags, keepMask;

  assign parityOn = parMode[1];
  assign rdData   = regRdEn && (regAddr == ADDR_DATA);
  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);

  always_comb begin
    setFlags = '0;
    if (strb.stopBit) begin
      setFlags[BIT_PAR] = parBad && parityOn;
      setFlags[BIT_FRM] = !strb.level;
      setFlags[BIT_OVR] = bufFull && !rdData;
    end
    keepMask = wrStatus ? regWrData[2:0] : 3'b111;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBuf    <= '0;
      parBad   <= 1'b0;
      bufFull  <= 1'b0;
      rxIrq    <= 1'b0;
      errFlags <= '0;
      parMode  <= 2'b00;
    end else begin
      if (strb.dataBit) shiftReg <= {strb.level, shiftReg[DATA_BITS-1:1]};
      if (strb.parityBit) parBad <= strb.level != ((^shiftReg) ^ parMode[0]);
      else if (strb.stopBit) parBad <= 1'b0;
      if (strb.stopBit) begin
        rxBuf   <= shiftReg;
        bufFull <= 1'b1;
      end else if (rdData) begin
        bufFull <= 1'b0;
      end
      rxIrq    <= strb.stopBit;
      errFlags <= (errFlags & keepMask) | setFlags;
      if (regWrEn && regAddr == ADDR_CTRL) parMode <= regWrData[1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_DATA:   regRdData = rxBuf;
      ADDR_STATUS: begin
        regRdData[2:0]      = errFlags;
        regRdData[BIT_FULL] = bufFull;
      end
      ADDR_CTRL:   regRdData[1:0] = parMode;
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic [DIV_W-1:0]     divisor,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [DATA_BITS-1:0] regWrData,
  output logic [DATA_BITS-1:0] regRdData,
  output logic                 rxIrq
);

  rxStrobe_t  strb;
  logic       parityOn;
  logic [1:0] parMode;
  logic [2:0] errFlags;
  logic       bufFull;

  uart_rx_ctrl #(.DIV_W(DIV_W), .OSR(OSR), .DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .divisor(divisor),
    .parityOn(parityOn), .strb(strb)
  );

  uart_rx_dp #(.DATA_BITS(DATA_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxIrq(rxIrq),
    .parityOn(parityOn), .parMode(parMode), .errFlags(errFlags),
    .bufFull(bufFull)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rxIrq,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic [1:0] parMode,
  input logic [2:0] errFlags,
  input logic       bufFull
);

  // R2: the interrupt lasts a single cycle
  a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  // R4: the parity flag rises only when a parity mode was active
  a_r4_no_parity_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlags[0]) |-> $past(parMode[1]));

  // R6: an overrun rises only with a full buffer
  a_r6_overrun_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlags[2]) |-> bufFull);

  // R7: a data read empties the buffer unless a frame lands at once
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regRdEn && regAddr == 2'd0) && !rxIrq) |-> !bufFull);

  for (genvar k = 0; k < 3; k++) begin : g_flag
    // R3: an error flag rises together with the interrupt
    a_r3_set_with_irq: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errFlags[k]) |-> rxIrq);
    // R8: a flag falls only after a status write with a 0 in its bit
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
      $fell(errFlags[k]) |-> $past(regWrEn && regAddr == 2'd1 && !regWrData[k]));
  end

endmodule

bind uart_rx_status uart_rx_checker i_chk (
  .clk(clk), .rstN(rstN), .rxIrq(rxIrq), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
  .parMode(parMode), .errFlags(errFlags), .bufFull(bufFull)
);

// File: tb/test_uart_rx_status.sv
`timescale 1ns/1ps
module test_uart_rx_status;

  localparam int BITCLK = 64;  // divisor 4 x 16 ticks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic [7:0] divisor = 8'd4;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       rxIrq;

  int nChecks = 0;
  int nFails  = 0;
  int irqCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .divisor(divisor),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxIrq(rxIrq)
  );

  always @(negedge clk) if (rstN && rxIrq) irqCount++;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, input bit strobe, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    regRdEn = strobe;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic lineBit(input logic v);
    rxIn = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit withPar, input logic parVal,
                           input logic stopVal);
    @(negedge clk);
    lineBit(1'b0);
    for (int i = 0; i < 8; i++) lineBit(d[i]);
    if (withPar) lineBit(parVal);
    lineBit(stopVal);
    rxIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expectFrame(string req, int irqBefore, logic [7:0] st, logic [7:0] d);
    logic [7:0] v;
    check({req, " irq count"}, irqCount - irqBefore, 1);
    readReg(2'd1, 1'b0, v);
    check({req, " status"}, v, st);
    readReg(2'd0, 1'b1, v);
    check({req, " data"}, v, d);
  endtask

  task automatic tReset();
    logic [7:0] v;
    readReg(2'd1, 1'b0, v); check("R1 status", v, 8'h00);
    readReg(2'd0, 1'b0, v); check("R1 data", v, 8'h00);
    check("R1 irq", rxIrq, 0);
  endtask

  task automatic tPlain();
    int c = irqCount;
    logic [7:0] v;
    writeReg(2'd2, 8'h00);
    sendFrame(8'hA5, 0, 0, 1);
    expectFrame("R2 plain A5", c, 8'h08, 8'hA5);
    readReg(2'd1, 1'b0, v); check("R7 full cleared by read", v, 8'h00);
    c = irqCount;
    sendFrame(8'h6E, 0, 0, 1);
    expectFrame("R2 plain 6E", c, 8'h08, 8'h6E);
  endtask

  task automatic tParity();
    int c;
    logic [7:0] v;
    writeReg(2'd2, 8'h02);               // even
    c = irqCount; sendFrame(8'h3C, 1, 1'b0, 1);
    expectFrame("R3 even good", c, 8'h08, 8'h3C);
    c = irqCount; sendFrame(8'h3C, 1, 1'b1, 1);
    expectFrame("R3 even bad", c, 8'h09, 8'h3C);
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, 1'b0, v); check("R8 write ones keeps flag", v, 8'h01);
    writeReg(2'd1, 8'hFE);
    readReg(2'd1, 1'b0, v); check("R8 write zero clears flag", v, 8'h00);
    writeReg(2'd2, 8'h03);               // odd
    c = irqCount; sendFrame(8'h01, 1, 1'b0, 1);
    expectFrame("R3 odd good", c, 8'h08, 8'h01);
    c = irqCount; sendFrame(8'h01, 1, 1'b1, 1);
    expectFrame("R3 odd bad", c, 8'h09, 8'h01);
    writeReg(2'd1, 8'h00);
  endtask

  task automatic tNoParity();
    int c;
    writeReg(2'd2, 8'h01);               // reserved = none
    c = irqCount; sendFrame(8'h55, 0, 0, 1);
    expectFrame("R4 mode 01 no parity bit", c, 8'h08, 8'h55);
    writeReg(2'd2, 8'h00);
    c = irqCount; sendFrame(8'hD3, 0, 0, 1);   // odd ones count, no flag
    expectFrame("R4 mode 00 no parity bit", c, 8'h08, 8'hD3);
  endtask

  task automatic tFraming();
    int c = irqCount;
    logic [7:0] v;
    @(negedge clk);
    lineBit(1'b0);
    for (int i = 0; i < 8; i++) lineBit(logic'((8'h81 >> i) & 1));
    lineBit(1'b0);                       // bad stop, line stays low
    repeat (3 * BITCLK) @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    expectFrame("R5 framing", c, 8'h0A, 8'h81);
    writeReg(2'd1, 8'h00);
    c = irqCount; sendFrame(8'h42, 0, 0, 1);
    expectFrame("R5 recover after high", c, 8'h08, 8'h42);
  endtask

  task automatic tOverrun();
    int c = irqCount;
    logic [7:0] v;
    sendFrame(8'h11, 0, 0, 1);
    sendFrame(8'h22, 0, 0, 1);
    check("R6 irq per frame", irqCount - c, 2);
    readReg(2'd1, 1'b0, v); check("R6 overrun status", v, 8'h0C);
    readReg(2'd0, 1'b1, v); check("R6 newer byte kept", v, 8'h22);
    writeReg(2'd1, 8'h00);
    readReg(2'd1, 1'b0, v); check("R8 overrun cleared", v, 8'h00);
  endtask

  task automatic tSetWins();
    logic [7:0] v;
    @(negedge clk);
    regAddr = 2'd1; regWrData = 8'h00; regWrEn = 1'b1;
    fork
      sendFrame(8'h99, 0, 0, 0);
      begin
        do @(negedge clk); while (!rxIrq);
        regWrEn = 1'b0;
      end
    join
    rxIn = 1'b1;
    repeat (BITCLK) @(negedge clk);
    readReg(2'd1, 1'b0, v); check("R9 set beats clear", v & 8'h07, 8'h02);
    readReg(2'd0, 1'b1, v);
    writeReg(2'd1, 8'h00);
  endtask

  task automatic tGlitch();
    int c = irqCount;
    logic [7:0] v;
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BITCLK / 4) @(negedge clk);
    rxIn = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    check("R10 glitch no irq", irqCount - c, 0);
    readReg(2'd1, 1'b0, v); check("R10 glitch no byte", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tPlain();
    tParity();
    tNoParity();
    tFraming();
    tOverrun();
    tSetWins();
    tGlitch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule